// File: doc/BRIEF.md
# Parity-Checked Line Input Assembler

The block takes a stream of 8-bit terminal characters over a valid/ready handshake and builds one text line in a small local buffer. Every byte carries a 7-bit character in bits 6:0 and an even-parity bit in bit 7. A byte whose eight bits hold an odd number of ones stops assembly with a parity error and is not stored. Every good byte is stored with bit 7 cleared.

A carriage return (0Dh) closes the line. It is stored, and on the next cycle a line feed (0Ah) is written after it without any input. If 81 characters arrive with no carriage return, the line closes with an overflow code. Once a line is closed, no byte is accepted until a start pulse clears the count, the code and the error flag. A host reads the buffer through a combinational read port and reads the count and the outcome.

Top module: `line_assembler`

## Requirements
- R1: After reset `count` is 0, `code` is 0 (in progress), `par_err` is 0 and `in_ready` is 1.
- R2: An accepted byte with an odd number of ones in its eight bits sets `par_err` on the next cycle. It is not stored, `count` does not change, `code` stays 0 and `in_ready` drops.
- R3: An accepted even-parity byte is written at buffer index `count` as {0, bits 6:0}, so bit 7 is always 0, and `count` rises by one.
- R4: An accepted byte whose low seven bits equal 0Dh is stored. On the following cycle 0Ah is written at the next index, `count` includes it, and `code` becomes 2 (line complete).
- R5: `in_ready` is 0 in the cycle in which the line feed is written.
- R6: When the 81st stored character is not 0Dh, `code` becomes 1 (overflow), `count` is 81 and `in_ready` drops.
- R7: When the 81st character is 0Dh, the line completes normally: `code` is 2 and `count` is 82, with 0Dh at index 80 and 0Ah at index 81.
- R8: While `code` is nonzero or `par_err` is 1, `in_ready` is 0 and input bytes change neither the count, the code nor the buffer.
- R9: A `start` pulse clears `count`, `code` and `par_err` and raises `in_ready` on the next cycle. A byte presented in the same cycle as `start` is not taken.
- R10: `rd_data` shows the buffer byte at `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clear pulse that opens a new line |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte: parity in bit 7, character in bits 6:0 |
| in_ready | output | 1 | Block can take a byte this cycle |
| rd_addr | input | 7 | Buffer read index |
| rd_data | output | 8 | Buffer byte at rd_addr |
| count | output | 7 | Number of bytes stored in the line |
| code | output | 2 | 0 in progress, 1 overflow, 2 complete |
| par_err | output | 1 | A parity error stopped assembly |

## Verification
The assertions assume that `in_data` is stable and known whenever `in_valid` is high, and that `start` is a single-cycle pulse that may overlap a presented byte. The stimulus drives all inputs on the falling edge and holds each byte until the block takes it. It uses only printable characters and carriage returns, with correct or deliberately wrong parity. The one deliberate overlap presents a byte in the same cycle as `start` to exercise the priority in R9.

// File: rtl/line_assembler.sv
module line_assembler #(
  parameter int LINE_MAX = 81,
  parameter int DEPTH    = LINE_MAX + 1,
  parameter int AW       = $clog2(DEPTH),
  parameter int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count,
  output logic [1:0]    code,
  output logic          par_err
);
  localparam logic [7:0] CHR_CR = 8'h0D;
  localparam logic [7:0] CHR_LF = 8'h0A;
  localparam logic [1:0] C_BUSY = 2'd0;
  localparam logic [1:0] C_OVF  = 2'd1;
  localparam logic [1:0] C_LINE = 2'd2;

  typedef enum logic [1:0] {S_RUN, S_LF, S_HOLD} st_t;
  st_t st;

  logic [7:0] mem [DEPTH];
  logic       take, odd, we;
  logic [7:0] chr, wd;

  assign in_ready = (st == S_RUN);
  assign take     = in_valid && in_ready && !start;
  assign odd      = ^in_data;
  assign chr      = {1'b0, in_data[6:0]};
  assign we       = (take && !odd) || (st == S_LF && !start);
  assign wd       = (st == S_LF) ? CHR_LF : chr;
  assign rd_data  = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;

  always_ff @(posedge clk)
    if (we) mem[count[AW-1:0]] <= wd;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      st      <= S_RUN;
      count   <= '0;
      code    <= C_BUSY;
      par_err <= 1'b0;
    end else begin
      case (st)
        S_RUN:
          if (take) begin
            if (odd) begin
              par_err <= 1'b1;
              st      <= S_HOLD;
            end else begin
              count <= count + CW'(1);
              if (chr == CHR_CR) st <= S_LF;
              else if (count == CW'(LINE_MAX - 1)) begin
                code <= C_OVF;
                st   <= S_HOLD;
              end
            end
          end
        S_LF: begin
          count <= count + CW'(1);
          code  <= C_LINE;
          st    <= S_HOLD;
        end
        default: ;
      endcase
    end
  end
endmodule

module line_assembler_chk #(
  parameter int LINE_MAX = 81,
  parameter int DEPTH    = LINE_MAX + 1,
  parameter int CW       = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          in_valid,
  input logic [7:0]    in_data,
  input logic          in_ready,
  input logic [CW-1:0] count,
  input logic [1:0]    code,
  input logic          par_err
);
  a_r2_parity_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !start && (^in_data)) |=>
      (par_err && count == $past(count) && code == 2'd0 && !in_ready));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !start && !(^in_data)) |=> (count == $past(count) + CW'(1)));

  a_r5_lf_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code == 2'd2) |-> !$past(in_ready));

  a_r6_overflow_count: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 2'd1) |-> (count == CW'(LINE_MAX) && !in_ready));

  a_r8_closed_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (code != 2'd0 || par_err) |-> !in_ready);

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == '0 && code == 2'd0 && !par_err && in_ready));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
endmodule

bind line_assembler line_assembler_chk #(.LINE_MAX(LINE_MAX), .DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/line_assembler_tb.sv
module line_assembler_tb;
  localparam int LINE_MAX = 81;
  localparam int DEPTH = LINE_MAX + 1;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [CW-1:0] count;
  logic [1:0] code;
  logic par_err;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  line_assembler #(.LINE_MAX(LINE_MAX)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: present byte, wait for acceptance, queue expected stored value
  task automatic send(input logic [6:0] ch, input bit bad, input bit push);
    @(negedge clk);
    in_valid = 1;
    in_data = bad ? {~(^ch), ch} : {^ch, ch};
    if (push && !bad) exp_q.push_back({1'b0, ch});
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor: read buffer and compare against queued expectations
  task automatic check_buf(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      rd_addr = AW'(i);
      #1;
      e = exp_q.pop_front();
      chk(rd_data === e, req, rd_data, e);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(count == 0, "R1 count", count, 0);
    chk(code == 0, "R1 code", code, 0);
    chk(par_err == 0, "R1 err", par_err, 0);
    chk(in_ready == 1, "R1 ready", in_ready, 1);

    // R3 R4 R5: short line, 'C' carries parity bit 1
    send(7'h48, 0, 1);
    send(7'h43, 0, 1);
    send(7'h0D, 0, 1);
    exp_q.push_back(8'h0A);
    chk(in_ready == 0, "R5 ready low on LF cycle", in_ready, 0);
    chk(code == 0, "R5 code before LF", code, 0);
    @(negedge clk);
    chk(code == 2, "R4 code", code, 2);
    chk(count == 4, "R4 count", count, 4);
    check_buf(4, "R3_R4 buffer");

    // R8: closed line ignores bytes
    in_valid = 1; in_data = 8'h5A;
    repeat (3) @(negedge clk);
    in_valid = 0;
    chk(count == 4, "R8 count held", count, 4);
    chk(code == 2, "R8 code held", code, 2);
    chk(in_ready == 0, "R8 ready", in_ready, 0);
    rd_addr = 0; #1;
    chk(rd_data == 8'h48, "R8 buffer held", rd_data, 8'h48);

    // R9: start with a byte presented in the same cycle
    @(negedge clk);
    start = 1; in_valid = 1; in_data = 8'hD1;
    @(negedge clk);
    start = 0; in_valid = 0;
    chk(count == 0, "R9 count", count, 0);
    chk(code == 0, "R9 code", code, 0);
    chk(in_ready == 1, "R9 ready", in_ready, 1);

    // R2: parity error
    send(7'h41, 0, 1);
    send(7'h42, 0, 1);
    send(7'h44, 1, 1);
    chk(par_err == 1, "R2 err", par_err, 1);
    chk(count == 2, "R2 count", count, 2);
    chk(code == 0, "R2 code", code, 0);
    chk(in_ready == 0, "R2 ready", in_ready, 0);
    check_buf(2, "R2 buffer");
    pulse_start();
    chk(par_err == 0, "R9 err cleared", par_err, 0);

    // R6: overflow
    for (int i = 0; i < LINE_MAX; i++) send(7'(8'h61 + i % 26), 0, 1);
    chk(code == 1, "R6 code", code, 1);
    chk(count == LINE_MAX, "R6 count", count, LINE_MAX);
    chk(in_ready == 0, "R6 ready", in_ready, 0);
    check_buf(LINE_MAX, "R6 buffer");

    // R7: CR as 81st character
    pulse_start();
    for (int i = 0; i < LINE_MAX - 1; i++) send(7'(8'h30 + i % 10), 0, 1);
    send(7'h0D, 0, 1);
    exp_q.push_back(8'h0A);
    @(negedge clk);
    chk(code == 2, "R7 code", code, 2);
    chk(count == DEPTH, "R7 count", count, DEPTH);
    check_buf(DEPTH, "R7_R10 buffer");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule